// File: doc/BRIEF.md
# Window Watchdog with Hysteresis

This block supervises a microcontroller that is expected to toggle a trigger line at a steady rate. It measures the time between rising edges of that line in ticks of a separate time base. That time base reaches the block as a tick-enable pulse in the same clock domain. Each measured period is graded good when it falls inside a window and bad when it is too short or too long. The grades feed a saturating score from 0 to 3, which drives an ok flag with set/reset behaviour. Three good triggers in a row from the fault state release the enables. Three bad triggers in a row from the ok state lock them.

Once the block is in the ok state, the window widens by one tick at both ends. This gives hysteresis at the margins. A trigger line that stops toggling is caught by a timeout, which drops the ok flag at once. An error signal from the time-base oscillator forces the same cleared state. A synchronous reset for power-on or a supply fault puts the block into its initial fault state.

Top module: `window_watchdog`

## Requirements
- R1: While and after `rst` is high at a clock edge, the score is 0 and the ok flag is clear: `wd_ok`=0, `en_pos`=0, `en_neg`=1.
- R2: The trigger passes through two flops clocked by ticks, and a rising edge is detected on the tick after that. The period is the number of ticks between two detected edges. In the fault state a period from 80 to 170 ticks, inclusive, is good; any other period is bad.
- R3: The score saturates at 3 and at 0. A good grade adds 1 and a bad grade subtracts 1.
- R4: The ok flag is set on the clock edge where the score becomes 3 and cleared where it becomes 0. At other scores the flag keeps its value.
- R5: If the block is armed and 250 ticks pass with no edge detected, the score goes to 0 and the ok flag clears at once, without waiting for an edge. An edge at a distance of exactly 250 ticks is graded (as bad) and does not time out.
- R6: While the ok flag is set, the good window runs from 79 to 171 ticks, inclusive.
- R7: A high `osc_fail` at a clock edge clears the score and the ok flag. It takes priority over a grade that falls on the same edge.
- R8: `en_pos` equals the ok flag and `en_neg` is its inverse.
- R9: The first edge after reset or after a timeout arms the block and restarts the period count. That edge is not graded.
- R10: While `tick_en` is low, the period count, the synchronizer and the timeout do not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high (power-on or supply fault) |
| tick_en | input | 1 | One-cycle pulse for each time-base tick |
| trig_in | input | 1 | Asynchronous trigger line from the supervised controller |
| osc_fail | input | 1 | Time-base oscillator error, active high |
| wd_ok | output | 1 | Watchdog ok flag |
| en_pos | output | 1 | Enable, high when ok |
| en_neg | output | 1 | Enable, low when ok |

## Verification
An oscillator error can land on the same clock edge that grades a trigger period. The bench provokes this by raising `osc_fail` exactly on the grading edge of an otherwise good trigger while the block is at full score. It then judges the outcome by requiring the ok flag to be clear and by showing that two more good triggers still leave it clear, which means the score really restarted from 0. The timeout and a grade can also meet at the 250-tick boundary. A trigger at exactly 250 ticks must be graded bad and leave the flag set, while a 260-tick gap must clear the flag before the late edge arrives.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    // Outcome of one trigger period evaluation
    typedef enum logic [1:0] {
        GR_NONE = 2'd0,
        GR_GOOD = 2'd1,
        GR_BAD  = 2'd2
    } grade_e;

endpackage

// File: rtl/wwd_edge.sv
module wwd_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic trig_i,
    output logic rise_o
);
    // Synchronizer chain plus one history flop for edge detection
    logic [STAGES:0] sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        if (tick_i) begin
            sync_d = {sync_q[STAGES-1:0], trig_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

endmodule

// File: rtl/wwd_period.sv
module wwd_period
    import wwd_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int WIN_LO  = 80,
    parameter int WIN_HI  = 170,
    parameter int TIMEOUT = 250
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   rise_i,
    input  logic   ok_i,
    output grade_e grade_o,
    output logic   stall_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] LO_FLT  = CNT_W'(WIN_LO);
    localparam logic [CNT_W-1:0] HI_FLT  = CNT_W'(WIN_HI);
    localparam logic [CNT_W-1:0] LO_OK   = CNT_W'(WIN_LO - 1);
    localparam logic [CNT_W-1:0] HI_OK   = CNT_W'(WIN_HI + 1);
    localparam logic [CNT_W-1:0] TO_LIM  = CNT_W'(TIMEOUT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } per_t;

    per_t per_d, per_q;
    logic [CNT_W-1:0] win_lo, win_hi;

    always_comb begin
        per_d   = per_q;
        grade_o = GR_NONE;
        stall_o = 1'b0;
        // One-tick hysteresis: window widens on both sides in ok state
        win_lo  = ok_i ? LO_OK : LO_FLT;
        win_hi  = ok_i ? HI_OK : HI_FLT;
        if (tick_i) begin
            if (rise_i) begin
                if (per_q.armed) begin
                    grade_o = (per_q.cnt >= win_lo && per_q.cnt <= win_hi)
                              ? GR_GOOD : GR_BAD;
                end
                per_d.cnt   = CNT_ONE;
                per_d.armed = 1'b1;
            end else begin
                if (per_q.cnt != CNT_MAX) begin
                    per_d.cnt = per_q.cnt + CNT_ONE;
                end
                if (per_q.armed && per_q.cnt >= TO_LIM) begin
                    stall_o     = 1'b1;
                    per_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
        end else begin
            per_q <= per_d;
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(per_q.cnt));

    // R2
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !rise_i && per_q.cnt == CNT_MAX) |=> (per_q.cnt == CNT_MAX));

endmodule

// File: rtl/wwd_score.sv
module wwd_score
    import wwd_pkg::*;
#(
    parameter int SCORE_MAX = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  grade_e grade_i,
    input  logic   stall_i,
    input  logic   osc_fail_i,
    output logic   ok_o
);
    localparam int SCORE_W = $clog2(SCORE_MAX + 1);
    localparam logic [SCORE_W-1:0] SC_TOP = SCORE_W'(SCORE_MAX);
    localparam logic [SCORE_W-1:0] SC_ONE = SCORE_W'(1);

    typedef struct packed {
        logic [SCORE_W-1:0] score;
        logic               ok;
    } sc_t;

    sc_t sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (osc_fail_i || stall_i) begin
            sc_d.score = '0;
            sc_d.ok    = 1'b0;
        end else if (grade_i != GR_NONE) begin
            case (grade_i)
                GR_GOOD: if (sc_q.score != SC_TOP) sc_d.score = sc_q.score + SC_ONE;
                GR_BAD:  if (sc_q.score != '0)     sc_d.score = sc_q.score - SC_ONE;
                default: sc_d.score = sc_q.score;
            endcase
            if (sc_d.score == SC_TOP) begin
                sc_d.ok = 1'b1;
            end else if (sc_d.score == '0) begin
                sc_d.ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign ok_o = sc_q.ok;

    // R7
    osc_clr_chk: assert property (@(posedge clk) disable iff (rst)
        osc_fail_i |=> (sc_q.score == '0 && !sc_q.ok));

    // R5
    stall_clr_chk: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> !ok_o);

    // R4
    ok_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sc_q.ok) |-> (sc_q.score == SC_TOP));

    // R4
    ok_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sc_q.ok) |-> (sc_q.score == '0));

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wwd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8,
    parameter int WIN_LO      = 80,
    parameter int WIN_HI      = 170,
    parameter int TIMEOUT     = 250,
    parameter int SCORE_MAX   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic trig_in,
    input  logic osc_fail,
    output logic wd_ok,
    output logic en_pos,
    output logic en_neg
);
    logic   rise;
    logic   stall;
    logic   ok;
    grade_e grade;

    wwd_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_en),
        .trig_i (trig_in),
        .rise_o (rise)
    );

    wwd_period #(
        .CNT_W   (CNT_W),
        .WIN_LO  (WIN_LO),
        .WIN_HI  (WIN_HI),
        .TIMEOUT (TIMEOUT)
    ) u_period (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_en),
        .rise_i  (rise),
        .ok_i    (ok),
        .grade_o (grade),
        .stall_o (stall)
    );

    wwd_score #(
        .SCORE_MAX (SCORE_MAX)
    ) u_score (
        .clk        (clk),
        .rst        (rst),
        .grade_i    (grade),
        .stall_i    (stall),
        .osc_fail_i (osc_fail),
        .ok_o       (ok)
    );

    assign wd_ok  = ok;
    assign en_pos = ok;
    assign en_neg = ~ok;

endmodule

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TO_TICKS   = 250;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b1;
    logic trig_in = 1'b0;
    logic osc_fail = 1'b0;
    logic wd_ok, en_pos, en_neg;

    int n_tests = 0;
    int n_fail  = 0;
    int since   = 0;
    int m_score = 0;
    bit m_ok    = 1'b0;
    bit m_armed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    window_watchdog u_window_watchdog (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .trig_in  (trig_in),
        .osc_fail (osc_fail),
        .wd_ok    (wd_ok),
        .en_pos   (en_pos),
        .en_neg   (en_neg)
    );

    task automatic step();
        @(negedge clk);
        if (tick_en) since++;
    endtask

    task automatic check(input string req);
        n_tests++;
        if (wd_ok !== m_ok || en_pos !== m_ok || en_neg !== !m_ok) begin
            n_fail++;
            $display("FAIL %s: wd_ok=%b en_pos=%b en_neg=%b expected ok=%b pos=%b neg=%b",
                     req, wd_ok, en_pos, en_neg, m_ok, m_ok, !m_ok);
        end
    endtask

    // Model one graded edge (R2, R3, R4, R6)
    task automatic model_grade(input int gap);
        int lo, hi;
        lo = m_ok ? 79 : 80;
        hi = m_ok ? 171 : 170;
        if (gap >= lo && gap <= hi) begin
            if (m_score < 3) m_score++;
        end else begin
            if (m_score > 0) m_score--;
        end
        if (m_score == 3) m_ok = 1'b1;
        else if (m_score == 0) m_ok = 1'b0;
    endtask

    // Rising edge 'gap' ticks after the previous one; checked after grading
    task automatic pulse(input int gap, input string req, input bit osc_at_grade = 1'b0);
        while (since < gap) step();
        if (m_armed && gap > TO_TICKS) begin
            m_score = 0; m_ok = 1'b0; m_armed = 1'b0;
            if (gap >= 254) check("R5 timeout before late edge");
        end
        trig_in = 1'b1;
        since = 0;
        step();
        step();
        trig_in = 1'b0;
        if (osc_at_grade) osc_fail = 1'b1;
        step();
        osc_fail = 1'b0;
        if (osc_at_grade) begin
            m_score = 0; m_ok = 1'b0;
        end else if (m_armed) begin
            model_grade(gap);
        end
        m_armed = 1'b1;
        check(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int plist[10] = '{77, 78, 79, 80, 81, 169, 170, 171, 172, 173};
        repeat (4) @(negedge clk);
        check("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset");

        // R9: first edge only arms, then three good releases (R4, R8)
        pulse(10, "R9 arm");
        pulse(100, "R4 one good");
        pulse(100, "R4 two good");
        pulse(100, "R4 three good");

        // R2/R6 window sweep in both states
        foreach (plist[i]) begin
            pulse(100, "R4 refill");
            pulse(100, "R4 refill");
            pulse(100, "R4 refill");
            pulse(plist[i], "R6 ok-state boundary");
            pulse(30, "R3 fast");
            pulse(30, "R3 fast");
            pulse(plist[i], "R2 fault-state boundary");
            pulse(100, "R2 follow");
            pulse(100, "R2 follow");
            pulse(100, "R4 follow");
        end

        // R3 saturation at top and bottom
        for (int k = 0; k < 5; k++) pulse(100, "R3 saturate high");
        for (int k = 0; k < 3; k++) pulse(30, "R3 drain from top");
        for (int k = 0; k < 5; k++) pulse(200, "R3 saturate low");
        for (int k = 0; k < 3; k++) pulse(100, "R3 climb from bottom");

        // R5 boundary: exactly 250 ticks is graded, not timed out
        pulse(250, "R5 edge at 250");
        pulse(30, "R5 after 250");
        pulse(30, "R5 after 250");
        for (int k = 0; k < 3; k++) pulse(100, "R4 refill");

        // R5/R9: timeout clears, late edge not graded
        pulse(260, "R9 late edge arms");
        pulse(100, "R9 regrade");
        pulse(100, "R9 regrade");
        pulse(100, "R9 regrade");

        // R7: oscillator error between edges
        osc_fail = 1'b1;
        step();
        osc_fail = 1'b0;
        m_score = 0; m_ok = 1'b0;
        check("R7 osc clear");
        pulse(100, "R7 score restarted");
        pulse(100, "R7 score restarted");
        pulse(100, "R7 score restarted");

        // R7: oscillator error on the grading edge of a good trigger
        pulse(100, "R7 osc on grade", 1'b1);
        pulse(100, "R7 after collision");
        pulse(100, "R7 after collision");
        pulse(100, "R7 after collision");

        // R10: frozen time base must not time out
        tick_en = 1'b0;
        repeat (300) @(negedge clk);
        check("R10 no tick no timeout");
        tick_en = 1'b1;
        pulse(100, "R10 period counted in ticks");
        for (int k = 0; k < 3; k++) pulse(30, "R10 score kept");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule